// File: doc/BRIEF.md
# Quadrature Encoder Position Counter

This block turns the two phase-shifted square waves of an incremental rotary encoder into a position count. Each phase input passes through a two-flop synchroniser. The block then compares the previous and current phase pair to decide whether the shaft has moved one step forward, one step back, or jumped illegally. The count rises for forward motion and falls for reverse motion, and it follows reversals one step at a time. It can count every edge of both phases (x4), or only the edges of one chosen phase (x2). In x2 mode the direction is still decoded from both phases.

The counter wraps at a programmable reload value. When the reload is set to counts per revolution minus one, the count is the shaft angle with no further arithmetic. A smaller reload gives several wrap events per turn, and a reload of all ones gives a free-running counter. A one-cycle event pulse marks every wrap. A rising edge on the index input can clear the count to zero at the mechanical reference position.

Top module: `qenc_position`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `count` is 0, `dir_up` is 1, and `wrap_evt` and `err_evt` are 0.
- R2: In x4 mode (`x2_mode`=0), the phase pair {A,B} stepping through 00→01→11→10→00 increments `count` by one per step. The reverse order decrements it by one per step.
- R3: In x2 mode (`x2_mode`=1), only transitions in which the selected phase changes alter `count`. The selected phase is A when `x2_use_b`=0 and B when `x2_use_b`=1. Transitions of the other phase leave `count` unchanged.
- R4: On every legal transition, in either mode, `dir_up` becomes 1 for a forward step and 0 for a reverse step. This holds even when the step is not counted.
- R5: A counted forward step taken when `count` is at or above `reload` sets `count` to 0 and raises `wrap_evt` for exactly one cycle.
- R6: A counted reverse step taken when `count` is 0 sets `count` to `reload` and raises `wrap_evt` for exactly one cycle.
- R7: With `reload` = 16'hFFFF, the counter runs freely. A reverse step from 0 gives 65535, and a forward step from 65535 gives 0, each with a wrap pulse.
- R8: A transition in which both phases change at once leaves `count` and `dir_up` unchanged and raises `err_evt` for one cycle.
- R9: When `index_clear_en`=1, a rising edge on `enc_z` clears `count` to 0 without a wrap pulse. The clear takes priority over a step in the same cycle. When `index_clear_en`=0, `enc_z` has no effect.
- R10: A change on the phase or index inputs shows on the outputs at the third rising clock edge after the change, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enc_a | input | 1 | Encoder phase A, asynchronous |
| enc_b | input | 1 | Encoder phase B, asynchronous |
| enc_z | input | 1 | Encoder index, asynchronous |
| x2_mode | input | 1 | 0: count all edges (x4), 1: count one phase (x2) |
| x2_use_b | input | 1 | Phase counted in x2 mode: 0 = A, 1 = B |
| index_clear_en | input | 1 | Enables clearing the count on an index rising edge |
| reload | input | CNT_W | Highest count value before wrapping |
| count | output | CNT_W | Position count |
| dir_up | output | 1 | Last decoded direction, 1 = forward |
| wrap_evt | output | 1 | One-cycle pulse on overflow or underflow |
| err_evt | output | 1 | One-cycle pulse on an illegal double-phase change |

## Verification
The hardest situations to reach are a reverse underflow in x2 mode and an index edge that arrives in the same cycle as a counted step. In x2 mode the underflow lands only on every other phase transition. The first situation needs the phase walk to reach count 0 on a counted edge and then reverse. The bench sweeps the full Gray walk forward and back, across several reload values, in every counting mode. This makes sure every wrap point is reached from both directions. For the index case, the bench drives a phase step and the index edge on the same clock, so that both pass through the synchronisers together and meet at the counter in one cycle.

// File: rtl/qenc_pkg.sv
package qenc_pkg;

    typedef enum logic [1:0] {
        MV_NONE = 2'd0,
        MV_UP   = 2'd1,
        MV_DOWN = 2'd2,
        MV_BAD  = 2'd3
    } move_e;

    typedef struct packed {
        logic valid;     // legal single-phase move
        logic fwd;       // direction of the move
        logic count_en;  // move advances the counter in the active mode
        logic bad;       // both phases changed together
    } step_t;

    // position of a phase pair {A,B} along the forward Gray walk
    function automatic logic [1:0] gray_pos(input logic [1:0] ab);
        case (ab)
            2'b00:   gray_pos = 2'd0;
            2'b01:   gray_pos = 2'd1;
            2'b11:   gray_pos = 2'd2;
            default: gray_pos = 2'd3;
        endcase
    endfunction

    function automatic move_e classify(input logic [1:0] prev_ab,
                                       input logic [1:0] cur_ab);
        logic [1:0] delta;
        delta = gray_pos(cur_ab) - gray_pos(prev_ab);
        case (delta)
            2'd0:    classify = MV_NONE;
            2'd1:    classify = MV_UP;
            2'd3:    classify = MV_DOWN;
            default: classify = MV_BAD;
        endcase
    endfunction

endpackage

// File: rtl/qenc_sync.sv
module qenc_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst)
                    stage_q[s] <= '0;
                else if (s == 0)
                    stage_q[s] <= din;
                else
                    stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/qenc_decode.sv
module qenc_decode
    import qenc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  a_s,
    input  logic  b_s,
    input  logic  x2_mode,
    input  logic  x2_use_b,
    output step_t step
);
    logic [1:0] ab_q;
    logic       primed_q;
    logic [1:0] ab_now;
    move_e      mv;
    logic       sel_changed;

    assign ab_now = {a_s, b_s};

    always_ff @(posedge clk) begin
        if (rst) begin
            ab_q     <= 2'b00;
            primed_q <= 1'b0;
        end else begin
            ab_q     <= ab_now;
            primed_q <= 1'b1;
        end
    end

    always_comb begin
        mv          = primed_q ? classify(ab_q, ab_now) : MV_NONE;
        sel_changed = x2_use_b ? (ab_q[0] ^ ab_now[0]) : (ab_q[1] ^ ab_now[1]);
        step.valid    = (mv == MV_UP) || (mv == MV_DOWN);
        step.fwd      = (mv == MV_UP);
        step.bad      = (mv == MV_BAD);
        step.count_en = step.valid && (!x2_mode || sel_changed);
    end
endmodule

// File: rtl/qenc_counter.sv
module qenc_counter
    import qenc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  step_t            step,
    input  logic             clr,
    input  logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] count,
    output logic             dir_up,
    output logic             wrap_evt,
    output logic             err_evt
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            count    <= '0;
            dir_up   <= 1'b1;
            wrap_evt <= 1'b0;
            err_evt  <= 1'b0;
        end else begin
            wrap_evt <= 1'b0;
            err_evt  <= step.bad;
            if (step.valid)
                dir_up <= step.fwd;
            if (clr) begin
                count <= '0;
            end else if (step.count_en) begin
                if (step.fwd) begin
                    if (count >= reload) begin
                        count    <= '0;
                        wrap_evt <= 1'b1;
                    end else begin
                        count <= count + ONE;
                    end
                end else begin
                    if (count == '0) begin
                        count    <= reload;
                        wrap_evt <= 1'b1;
                    end else begin
                        count <= count - ONE;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/qenc_position.sv
module qenc_position
    import qenc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enc_a,
    input  logic             enc_b,
    input  logic             enc_z,
    input  logic             x2_mode,
    input  logic             x2_use_b,
    input  logic             index_clear_en,
    input  logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] count,
    output logic             dir_up,
    output logic             wrap_evt,
    output logic             err_evt
);
    localparam int SYNC_STAGES = 2;

    logic [2:0] raw_in;
    logic [2:0] sync_out;
    logic       z_q;
    logic       z_rise;
    step_t      step;

    assign raw_in = {enc_z, enc_a, enc_b};

    qenc_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (raw_in),
        .dout (sync_out)
    );

    always_ff @(posedge clk) begin
        if (rst) z_q <= 1'b0;
        else     z_q <= sync_out[2];
    end

    assign z_rise = sync_out[2] & ~z_q;

    qenc_decode u_dec (
        .clk      (clk),
        .rst      (rst),
        .a_s      (sync_out[1]),
        .b_s      (sync_out[0]),
        .x2_mode  (x2_mode),
        .x2_use_b (x2_use_b),
        .step     (step)
    );

    qenc_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .step     (step),
        .clr      (z_rise & index_clear_en),
        .reload   (reload),
        .count    (count),
        .dir_up   (dir_up),
        .wrap_evt (wrap_evt),
        .err_evt  (err_evt)
    );
endmodule

// File: rtl/qenc_position_chk.sv
module qenc_position_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic [CNT_W-1:0] reload,
    input logic [CNT_W-1:0] count,
    input logic             dir_up,
    input logic             wrap_evt,
    input logic             err_evt
);
    // R5: a forward wrap lands on zero
    assert_wrap_up_zero_R5: assert property (@(posedge clk) disable iff (rst)
        (wrap_evt && dir_up) |-> (count == '0));

    // R6: a reverse wrap lands on the reload value in force at that edge
    assert_wrap_down_reload_R6: assert property (@(posedge clk) disable iff (rst)
        (wrap_evt && !dir_up) |-> (count == $past(reload)));

    // R8: an illegal jump neither turns the direction nor wraps
    assert_bad_keeps_dir_R8: assert property (@(posedge clk) disable iff (rst)
        err_evt |-> ($stable(dir_up) && !wrap_evt));

    // R2: without a wrap the count moves by at most one, or is cleared (R9)
    assert_single_step_R2: assert property (@(posedge clk) disable iff (rst)
        ((count != $past(count)) && !wrap_evt) |->
            ((count == CNT_W'($past(count) + 1'b1)) ||
             (count == CNT_W'($past(count) - 1'b1)) ||
             (count == '0)));
endmodule

bind qenc_position qenc_position_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .reload   (reload),
    .count    (count),
    .dir_up   (dir_up),
    .wrap_evt (wrap_evt),
    .err_evt  (err_evt)
);

// File: tb/qenc_position_tb.sv
module qenc_position_tb;
    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             enc_a = 1'b0, enc_b = 1'b0, enc_z = 1'b0;
    logic             x2_mode = 1'b0, x2_use_b = 1'b0, index_clear_en = 1'b0;
    logic [CNT_W-1:0] reload = 16'd5;
    logic [CNT_W-1:0] count;
    logic             dir_up, wrap_evt, err_evt;

    int n_chk = 0;
    int n_bad = 0;
    int pos   = 0;   // Gray position of the driven phase pair
    int mdl   = 0;   // expected count

    always #4 clk = ~clk;

    qenc_position #(.CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst(rst), .enc_a(enc_a), .enc_b(enc_b), .enc_z(enc_z),
        .x2_mode(x2_mode), .x2_use_b(x2_use_b), .index_clear_en(index_clear_en),
        .reload(reload), .count(count), .dir_up(dir_up),
        .wrap_evt(wrap_evt), .err_evt(err_evt)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [1:0] ab_of(input int p);
        case (p)
            0: ab_of = 2'b00;
            1: ab_of = 2'b01;
            2: ab_of = 2'b11;
            default: ab_of = 2'b10;
        endcase
    endfunction

    // drive at negedge, let three rising edges pass, sample at negedge (R10)
    task automatic settle();
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic step(input bit fwd, input string tag);
        logic [1:0] old_ab, new_ab;
        bit counted, exp_wrap;
        int rl;
        rl = int'(reload);
        old_ab = ab_of(pos);
        pos = fwd ? (pos + 1) % 4 : (pos + 3) % 4;
        new_ab = ab_of(pos);
        counted = !x2_mode || (x2_use_b ? (old_ab[0] != new_ab[0])
                                        : (old_ab[1] != new_ab[1]));
        exp_wrap = 1'b0;
        if (counted) begin
            if (fwd) begin
                if (mdl >= rl) begin mdl = 0; exp_wrap = 1'b1; end
                else mdl = mdl + 1;
            end else begin
                if (mdl == 0) begin mdl = rl; exp_wrap = 1'b1; end
                else mdl = mdl - 1;
            end
        end
        {enc_a, enc_b} = new_ab;
        settle();
        chk(int'(count) == mdl, tag, int'(count), mdl);
        chk(dir_up == fwd, "R4 dir", int'(dir_up), int'(fwd));
        chk(wrap_evt == exp_wrap, exp_wrap ? "R5/R6 wrap" : "R5/R6 nowrap",
            int'(wrap_evt), int'(exp_wrap));
        @(negedge clk);
        chk(wrap_evt == 1'b0, "R5 pulse width", int'(wrap_evt), 0);
    endtask

    task automatic index_pulse(input bit en);
        index_clear_en = en;
        enc_z = 1'b1;
        settle();
        if (en) mdl = 0;
        chk(int'(count) == mdl, en ? "R9 clear" : "R9 ignored", int'(count), mdl);
        chk(wrap_evt == 1'b0, "R9 no wrap", int'(wrap_evt), 0);
        enc_z = 1'b0;
        settle();
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        chk(count == '0, "R1 count", int'(count), 0);
        chk(dir_up == 1'b1, "R1 dir", int'(dir_up), 1);
        chk(!wrap_evt && !err_evt, "R1 events", int'(wrap_evt | err_evt), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(count == '0 && dir_up, "R1 after release", int'(count), 0);
        settle();

        // R2 / R3 sweeps over modes and reload values
        for (int m = 0; m < 3; m++) begin
            x2_mode  = (m != 0);
            x2_use_b = (m == 2);
            for (int r = 0; r < 3; r++) begin
                reload = (r == 0) ? 16'd3 : (r == 1) ? 16'd5 : 16'd0;
                index_pulse(1'b1);
                for (int k = 0; k < 17; k++) step(1'b1, m == 0 ? "R2 fwd" : "R3 fwd");
                for (int k = 0; k < 23; k++) step(1'b0, m == 0 ? "R2 rev" : "R3 rev");
                for (int k = 0; k < 5; k++) begin
                    step(1'b1, "R2/R3 reversal");
                    step(1'b0, "R2/R3 reversal");
                end
            end
        end

        // R10: output must not change before the third edge
        x2_mode = 1'b0; reload = 16'd9;
        index_pulse(1'b1);
        begin
            logic [1:0] nab;
            pos = (pos + 1) % 4;
            nab = ab_of(pos);
            {enc_a, enc_b} = nab;
            repeat (2) @(posedge clk);
            @(negedge clk);
            chk(count == '0, "R10 early", int'(count), 0);
            @(posedge clk);
            @(negedge clk);
            mdl = 1;
            chk(count == 16'd1, "R10 on time", int'(count), 1);
        end

        // R8: double-phase jump
        begin
            logic [1:0] jab;
            bit d0;
            int c0;
            d0 = dir_up; c0 = int'(count);
            pos = (pos + 2) % 4;
            jab = ab_of(pos);
            {enc_a, enc_b} = jab;
            settle();
            chk(err_evt == 1'b1, "R8 err", int'(err_evt), 1);
            chk(int'(count) == c0, "R8 count", int'(count), c0);
            chk(dir_up == d0, "R8 dir", int'(dir_up), int'(d0));
            @(negedge clk);
            chk(err_evt == 1'b0, "R8 err pulse", int'(err_evt), 0);
        end

        // R9: ignored when disabled, then priority over a step
        step(1'b1, "R2 pre-index");
        index_pulse(1'b0);
        begin
            logic [1:0] nab;
            pos = (pos + 1) % 4;
            nab = ab_of(pos);
            index_clear_en = 1'b1;
            {enc_a, enc_b} = nab;
            enc_z = 1'b1;
            settle();
            mdl = 0;
            chk(count == '0, "R9 priority", int'(count), 0);
            enc_z = 1'b0;
            settle();
        end

        // R7: free-running full-width counter
        reload = 16'hFFFF;
        step(1'b0, "R7 underflow");
        chk(count == 16'hFFFF, "R7 value", int'(count), 65535);
        step(1'b1, "R7 overflow");
        step(1'b1, "R7 run");

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule